// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog reached through a small word-addressed register bus. A down-counter, either stepped on every clock or through a power-of-two prescaler, must be restarted by software before it runs out. A restart happens only when the service register receives an ordered two-word key. Any other sequence leaves the counter running. When the counter runs out, the block either raises a one-cycle reset request or raises an interrupt, depending on a mode bit. The interrupt stays raised until the next valid service. A sticky status bit records that a watchdog reset request was issued. Software clears it by writing 1 to it.

The control register can be written only once after power-on reset. The first write fixes the timeout count, the enable, the mode, the prescale choice and the freeze option. Every later control write is discarded, so software reads the register back to learn what took effect. When the freeze option is set, a debug-halt input stops the count. The register index is decoded from `bus_addr`: 0 selects control, 1 the count, 2 the service register and 3 the status register. Read data reflects the addressed register combinationally.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, control reads 0x0000_0000, the count register reads 0x0000_FFFF, status reads 0, and both `wdt_irq` and `wdt_rst_req` are low.
- R2: The control word holds the timeout in bits 31:16, freeze in bit 3, enable in bit 2, mode in bit 1 (1 = reset request, 0 = interrupt) and prescale-enable in bit 0. Other bits read as 0. The first control write loads the counter with the timeout, visible in the cycle after the write.
- R3: Once the first control write has happened, later control writes change neither the readback nor the enable state.
- R4: Writing 0x556C and then 0xAA39 to the service register (index 2, low 16 bits) reloads the counter from the timeout field and clears a raised interrupt.
- R5: A lone 0xAA39 is ignored. Any write that follows 0x556C and is not 0xAA39 (including a second 0x556C) cancels the sequence, so a following 0xAA39 is ignored.
- R6: With prescale off, the counter steps down once per clock. Expiry is seen exactly T clocks after the load or service, where T is the timeout.
- R7: With prescale on, the counter steps down once every 2^PRESCALE_LOG2 clocks. Expiry is seen T·2^PRESCALE_LOG2 clocks after the load.
- R8: In reset mode, expiry drives `wdt_rst_req` high for exactly one cycle (for T ≥ 2) and reloads the counter. `wdt_irq` stays low.
- R9: In interrupt mode, expiry raises `wdt_irq`, which stays high through further expiries until a valid service.
- R10: With freeze set, `debug_halt` high stops the count. With freeze clear, `debug_halt` has no effect.
- R11: The status bit (index 3, bit 0) sets when a reset request is issued and stays set until a write with bit 0 = 1 clears it.
- R12: While enable is 0, the counter holds its value and nothing expires.
- R13: The count register (index 1) is read-only, and writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| debug_halt | input | 1 | Debug halt request, honoured when freeze is set |
| wdt_irq | output | 1 | Sticky expiry interrupt |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with PRESCALE_LOG2 = 3, so a prescaled timeout lasts eight clocks per count. This lets the prescaled expiry be timed exactly within a few dozen cycles rather than millions. Timeouts of 3 to 40 counts keep the unprescaled expiries, the interrupt persisting across repeated expiries, and the key-sequence misuse cases short enough to be counted cycle by cycle. Each scenario starts from a fresh power-on reset, because the control register accepts only one write.

// File: rtl/wdt_pkg.sv
// Shared definitions for the keyed-service watchdog: control word layout,
// service keys, register indices and the configuration record.
package wdt_pkg;

    localparam int BUS_W      = 32;
    localparam int TO_W       = 16;
    localparam int TO_LSB     = 16;
    localparam int BIT_FREEZE = 3;
    localparam int BIT_EN     = 2;
    localparam int BIT_MODE   = 1;
    localparam int BIT_PRE    = 0;

    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    typedef enum logic [1:0] {
        RSEL_CTRL    = 2'd0,
        RSEL_COUNT   = 2'd1,
        RSEL_SERVICE = 2'd2,
        RSEL_STATUS  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_state_e;

    typedef struct packed {
        logic [TO_W-1:0] timeout;
        logic            freeze;
        logic            enable;
        logic            rst_mode;
        logic            prescale;
    } wdt_cfg_t;

    // Extract the configuration record from a control bus word.
    function automatic wdt_cfg_t unpack_ctrl(input logic [BUS_W-1:0] w);
        wdt_cfg_t c;
        c.timeout  = w[TO_LSB +: TO_W];
        c.freeze   = w[BIT_FREEZE];
        c.enable   = w[BIT_EN];
        c.rst_mode = w[BIT_MODE];
        c.prescale = w[BIT_PRE];
        return c;
    endfunction

    // Place the configuration record back into a control bus word.
    function automatic logic [BUS_W-1:0] pack_ctrl(input wdt_cfg_t c);
        logic [BUS_W-1:0] w;
        w                  = '0;
        w[TO_LSB +: TO_W]  = c.timeout;
        w[BIT_FREEZE]      = c.freeze;
        w[BIT_EN]          = c.enable;
        w[BIT_MODE]        = c.rst_mode;
        w[BIT_PRE]         = c.prescale;
        return w;
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
// Write-once configuration register.
// Accepts the first control write after power-on reset and locks;
// later writes are dropped. Assumes wr_en is a single-cycle strobe.
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output wdt_cfg_t         cfg,
    output logic             locked,
    output logic             load
);

    wdt_cfg_t cfg_q;
    logic     locked_q;

    // A write is taken only while the register is still open.
    assign load   = wr_en && !locked_q;
    assign cfg    = cfg_q;
    assign locked = locked_q;

    // Capture the first write and close the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
        end else if (load) begin
            cfg_q    <= unpack_ctrl(wdata);
            locked_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_key_seq.sv
// Service key sequencer.
// Tracks the ordered two-word key on the service register and issues a
// one-cycle service pulse when the second key follows the first directly.
// Assumes wr_en marks exactly one service write per cycle.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic        service
);

    key_state_e state_q, state_d;

    // The second key counts only while armed.
    assign service = wr_en && (state_q == KS_ARMED) && (wdata == KEY_SECOND);

    // Next state: arm on the first key from idle, fall back to idle on any
    // write seen while armed.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (state_q == KS_IDLE) begin
                state_d = (wdata == KEY_FIRST) ? KS_ARMED : KS_IDLE;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wdt_timer.sv
// Prescaler and down-counter.
// Counts down on each tick (every clock, or every 2^PRESCALE_LOG2 clocks
// when prescale is on) and flags expiry when a tick meets a count of one
// or zero. A reload clears the prescaler and wins over expiry.
// Assumes the configuration is stable except on the reload cycle.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRESCALE_LOG2 = 16,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_cfg_t         cfg,
    input  logic             debug_halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             run;
    logic             pre_tick;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    // Counting is live when enabled and not frozen by a debug halt.
    assign run = cfg.enable && !(cfg.freeze && debug_halt);

    generate
        if (PRESCALE_LOG2 > 0) begin : g_prescaler
            logic [PRESCALE_LOG2-1:0] pre_q;

            // Free-running divider, restarted on every reload.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (reload) begin
                    pre_q <= '0;
                end else if (run) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign pre_tick = &pre_q;
        end else begin : g_no_prescaler
            assign pre_tick = 1'b1;
        end
    endgenerate

    assign tick   = run && (cfg.prescale ? pre_tick : 1'b1);
    assign expire = tick && (cnt_q <= CNT_ONE) && !reload;
    assign count  = cnt_q;

    // Down-counter with reload on load, service or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (reload) begin
            cnt_q <= reload_val;
        end else if (expire) begin
            cnt_q <= cfg.timeout;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_alarm.sv
// Expiry outputs and sticky status.
// Turns an expiry into a one-cycle reset request or a held interrupt
// according to the mode bit, and keeps the watchdog-reset status flag.
// Assumes expire and service never arrive in the same cycle.
module wdt_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rst_mode,
    input  logic service,
    input  logic status_clr,
    output logic rst_req,
    output logic irq,
    output logic status
);

    // One-cycle reset request per expiry in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire && rst_mode;
        end
    end

    // Interrupt raised on expiry in interrupt mode, dropped by a service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (expire && !rst_mode) begin
            irq <= 1'b1;
        end else if (service) begin
            irq <= 1'b0;
        end
    end

    // Sticky status: a new reset request wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (expire && rst_mode) begin
            status <= 1'b1;
        end else if (status_clr) begin
            status <= 1'b0;
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
// Keyed-service watchdog top.
// Decodes the register bus, ties the write-once configuration, the key
// sequencer, the timer and the alarm logic together and drives read data.
// Assumes at most one register access per cycle; reads are combinational.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int PRESCALE_LOG2 = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        debug_halt,
    output logic        wdt_irq,
    output logic        wdt_rst_req
);

    localparam int CNT_W = TO_W;

    logic             wr_stb;
    logic             ctrl_wr;
    logic             svc_wr;
    logic             stat_wr;
    wdt_cfg_t         cfg_q;
    logic             cfg_locked;
    logic             cfg_load;
    logic             svc_pulse;
    logic             reload;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             status_q;
    reg_sel_e         rsel;

    // Write strobes per register.
    assign rsel    = reg_sel_e'(bus_addr);
    assign wr_stb  = bus_sel && bus_wr;
    assign ctrl_wr = wr_stb && (rsel == RSEL_CTRL);
    assign svc_wr  = wr_stb && (rsel == RSEL_SERVICE);
    assign stat_wr = wr_stb && (rsel == RSEL_STATUS);

    wdt_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (bus_wdata),
        .cfg    (cfg_q),
        .locked (cfg_locked),
        .load   (cfg_load)
    );

    wdt_key_seq u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (svc_wr),
        .wdata   (bus_wdata[15:0]),
        .service (svc_pulse)
    );

    // The first control write loads its own timeout; a service reuses the
    // stored one.
    assign reload     = cfg_load || svc_pulse;
    assign reload_val = cfg_load ? bus_wdata[TO_LSB +: CNT_W] : cfg_q.timeout;

    wdt_timer #(
        .PRESCALE_LOG2 (PRESCALE_LOG2),
        .CNT_W         (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .debug_halt (debug_halt),
        .reload     (reload),
        .reload_val (reload_val),
        .count      (cnt_q),
        .expire     (expire)
    );

    wdt_alarm u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .rst_mode   (cfg_q.rst_mode),
        .service    (svc_pulse),
        .status_clr (stat_wr && bus_wdata[0]),
        .rst_req    (wdt_rst_req),
        .irq        (wdt_irq),
        .status     (status_q)
    );

    // Read multiplexer.
    always_comb begin
        case (rsel)
            RSEL_CTRL:   bus_rdata = pack_ctrl(cfg_q);
            RSEL_COUNT:  bus_rdata = {{(BUS_W-CNT_W){1'b0}}, cnt_q};
            RSEL_STATUS: bus_rdata = {{(BUS_W-1){1'b0}}, status_q};
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_checker.sv
// Property checker for keyed_wdt, attached by bind below.
module wdt_checker
    import wdt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rst_req,
    input logic        irq,
    input logic        svc,
    input logic        reload,
    input logic        ctrl_wr,
    input logic        locked,
    input logic        halt,
    input logic        status,
    input logic [15:0] count,
    input wdt_cfg_t    cfg
);

    // R3: a locked register ignores control writes
    a_r3_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ctrl_wr) |=> $stable(cfg));

    // R4: a service reloads the stored timeout
    a_r4_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (count == $past(cfg.timeout)));

    // R8: reset request lasts a single cycle for timeouts of two or more
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && cfg.timeout >= 16'd2) |=> !rst_req);

    // R8: the counter is reloaded when the request appears
    a_r8_reload_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == cfg.timeout));

    // R9: interrupt holds until serviced
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc) |=> irq);

    // R9: interrupt mode never requests a reset
    a_r9_no_req_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.rst_mode |-> !rst_req);

    // R10: frozen counter does not move
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.freeze && halt && !reload) |=> $stable(count));

    // R11: a reset request always leaves the status set
    a_r11_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> status);

    // R12: a disabled counter holds
    a_r12_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.enable && !reload) |=> $stable(count));

endmodule

bind keyed_wdt wdt_checker u_wdt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_req (wdt_rst_req),
    .irq     (wdt_irq),
    .svc     (svc_pulse),
    .reload  (reload),
    .ctrl_wr (ctrl_wr),
    .locked  (cfg_locked),
    .halt    (debug_halt),
    .status  (status_q),
    .count   (cnt_q),
    .cfg     (cfg_q)
);

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_LOG2   = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_SVC  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int K_RDATA = 0;
    localparam int K_IRQ   = 1;
    localparam int K_RST   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        debug_halt = 1'b0;
    logic        wdt_irq;
    logic        wdt_rst_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      chk_ev;

    keyed_wdt #(.PRESCALE_LOG2(PRE_LOG2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .debug_halt  (debug_halt),
        .wdt_irq     (wdt_irq),
        .wdt_rst_req (wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops expected items and compares them with the outputs.
    always begin
        @(chk_ev);
        #1;
        while (exp_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                K_IRQ:   act = {31'b0, wdt_irq};
                K_RST:   act = {31'b0, wdt_rst_req};
                default: act = bus_rdata;
            endcase
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        debug_halt = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Write: one capture edge, returns at the negedge after it.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Driver: queue expected register contents for the current cycle.
    task automatic rd_expect(input logic [1:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        bus_addr = a;
        it.kind = K_RDATA; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic pin_expect(input int k, input logic e, input string tag);
        exp_item_t it;
        it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [15:0] t, input logic [3:0] bits);
        return {t, 12'h000, bits};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // ---- R1 reset state, R12 unconfigured block holds ----
        do_reset();
        rd_expect(A_CTRL, 32'h0, "R1 ctrl");
        rd_expect(A_CNT, 32'h0000_FFFF, "R1 count");
        rd_expect(A_STAT, 32'h0, "R1 status");
        pin_expect(K_IRQ, 1'b0, "R1 irq");
        pin_expect(K_RST, 1'b0, "R1 rst_req");
        idle(20);
        rd_expect(A_CNT, 32'h0000_FFFF, "R12 unconfigured count");

        // ---- R2/R6/R8/R11: reset mode, no prescale, T=10 ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd10, 4'b0110));
        rd_expect(A_CTRL, 32'h000A_0006, "R2 readback");
        rd_expect(A_CNT, 32'd10, "R2 load");
        idle(3);
        rd_expect(A_CNT, 32'd7, "R6 step per clock");
        idle(6);
        rd_expect(A_CNT, 32'd1, "R6 before expiry");
        pin_expect(K_RST, 1'b0, "R6 no early request");
        idle(1);
        pin_expect(K_RST, 1'b1, "R8 request at T clocks");
        pin_expect(K_IRQ, 1'b0, "R8 irq stays low");
        rd_expect(A_CNT, 32'd10, "R8 reload");
        rd_expect(A_STAT, 32'd1, "R11 status set");
        idle(1);
        pin_expect(K_RST, 1'b0, "R8 single cycle");
        rd_expect(A_CNT, 32'd9, "R8 counting resumed");
        rd_expect(A_STAT, 32'd1, "R11 status sticky");
        wr(A_STAT, 32'h1);
        rd_expect(A_STAT, 32'd0, "R11 write-1 clear");

        // ---- R9/R4: interrupt mode, T=5 ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd5, 4'b0100));
        rd_expect(A_CNT, 32'd5, "R2 load irq mode");
        idle(5);
        pin_expect(K_IRQ, 1'b1, "R9 irq on expiry");
        pin_expect(K_RST, 1'b0, "R9 no reset request");
        rd_expect(A_CNT, 32'd5, "R9 reload");
        idle(7);
        pin_expect(K_IRQ, 1'b1, "R9 irq held");
        wr(A_SVC, 32'h556C);
        wr(A_SVC, 32'hAA39);
        pin_expect(K_IRQ, 1'b0, "R9 irq cleared by service");
        rd_expect(A_CNT, 32'd5, "R4 service reload");

        // ---- R5/R4/R3/R13: key misuse, T=40 ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd40, 4'b0100));
        rd_expect(A_CNT, 32'd40, "R2 load T=40");
        wr(A_SVC, 32'hAA39);
        rd_expect(A_CNT, 32'd38, "R5 lone second key");
        wr(A_SVC, 32'h556C);
        wr(A_SVC, 32'h1234);
        wr(A_SVC, 32'hAA39);
        rd_expect(A_CNT, 32'd32, "R5 sequence broken by other value");
        wr(A_SVC, 32'h556C);
        wr(A_SVC, 32'h556C);
        wr(A_SVC, 32'hAA39);
        rd_expect(A_CNT, 32'd26, "R5 repeated first key cancels");
        wr(A_SVC, 32'h556C);
        wr(A_SVC, 32'hAA39);
        rd_expect(A_CNT, 32'd40, "R4 ordered pair reloads");
        wr(A_CTRL, 32'h0);
        rd_expect(A_CTRL, 32'h0028_0004, "R3 rewrite ignored");
        rd_expect(A_CNT, 32'd38, "R3 still enabled");
        wr(A_CNT, 32'h7);
        rd_expect(A_CNT, 32'd36, "R13 count read-only");
        pin_expect(K_IRQ, 1'b0, "R5 no expiry");

        // ---- R7/R2: prescaled, T=3, P=8, extra bits written ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd3, 4'b0111) | 32'h0000_FFF0);
        rd_expect(A_CTRL, 32'h0003_0007, "R2 undefined bits read 0");
        idle(7);
        rd_expect(A_CNT, 32'd3, "R7 hold within prescale period");
        idle(1);
        rd_expect(A_CNT, 32'd2, "R7 step after 8 clocks");
        idle(15);
        rd_expect(A_CNT, 32'd1, "R7 before expiry");
        pin_expect(K_RST, 1'b0, "R7 no early request");
        idle(1);
        pin_expect(K_RST, 1'b1, "R7 request at T*P clocks");

        // ---- R10: freeze with halt ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd20, 4'b1100));
        debug_halt = 1'b1;
        idle(10);
        rd_expect(A_CNT, 32'd20, "R10 frozen");
        debug_halt = 1'b0;
        idle(4);
        rd_expect(A_CNT, 32'd16, "R10 resumes");

        // ---- R10: halt without freeze ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd20, 4'b0100));
        debug_halt = 1'b1;
        idle(4);
        rd_expect(A_CNT, 32'd16, "R10 halt ignored without freeze");
        debug_halt = 1'b0;

        // ---- R12/R3: configured disabled, enable attempt later ----
        do_reset();
        wr(A_CTRL, ctrl_word(16'd4, 4'b0010));
        rd_expect(A_CNT, 32'd4, "R12 load while disabled");
        idle(10);
        rd_expect(A_CNT, 32'd4, "R12 disabled holds");
        pin_expect(K_RST, 1'b0, "R12 no expiry");
        wr(A_CTRL, ctrl_word(16'd4, 4'b0110));
        rd_expect(A_CTRL, 32'h0004_0002, "R3 enable attempt ignored");
        idle(6);
        rd_expect(A_CNT, 32'd4, "R3 remains disabled");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule